// File: doc/BRIEF.md
# SDRAM Wake-up and Refresh Sequencer

This block sits on the controller side of an SDRAM rank. After reset it raises clock enable and then keeps the command bus quiet for a power-up pause of 200 µs. It then closes every bank with one precharge, runs a fixed burst of auto-refresh commands and writes the mode register from a small configuration word. Only after that does it open the command bus to the host.

Once the rank is running, an interval counter makes a refresh fall due on average every 15.625 µs, which spreads 4096 refreshes over 64 ms. Each due refresh is raised as a pending request. The grant to the host is withdrawn and no further host command reaches the pins. The block then issues an all-bank precharge followed by an auto-refresh, and hands the bus back once the bank cycle time has passed.

Commands leave as registered chip-select, row strobe, column strobe and write-enable levels together with address and bank outputs. Every time limit is given in nanoseconds and turned into whole clocks by rounding up, using the clock period parameter.

Top module: `sdram_wake_refresh`

## Requirements
- R1: While reset is held, clock enable is low, chip select is high and both done and grant are low. Clock enable goes high on the first clock after reset is released and then stays high.
- R2: Chip select stays high for ceil(200 µs / period) cycles after clock enable rises; 20000 cycles at 10 ns. The first command appears on the very next cycle.
- R3: The first command is a precharge, encoded as row strobe 0, column strobe 1, write enable 0. Address bit 10 is 1 so that all banks are closed, and the bank outputs are 0.
- R4: Eight auto-refresh commands follow, encoded as row strobe 0, column strobe 0, write enable 1. The first comes ceil(20 ns / period) cycles after the precharge, and the rest are spaced ceil(70 ns / period) cycles apart. No other sequencer command appears in between.
- R5: A mode-register write follows ceil(70 ns / period) cycles after the last initial refresh. It is encoded as all three strobes 0 with bank 0. Its address carries the burst-length code in bits 2:0 (0=1, 1=2, 2=4, 3=8, 7=full page), the burst type in bit 3 (1 = interleave) and the CAS latency in bits 6:4. All other address bits are 0.
- R6: When the burst-length code is 7 (full page) and interleave is requested, bit 3 of the mode word is written as 0 (sequential).
- R7: The done flag rises ceil(20 ns / period) cycles after the mode write and stays high. Grant stays low until the done flag is high.
- R8: Once done is high and nothing is pending, asserting the host request raises grant on the next clock. Each cycle in which grant and request are both high, the host command, address and bank appear on the pins one clock later with chip select low.
- R9: Host command inputs are ignored whenever grant is low: outside sequencer commands the pins show chip select high, all strobes high, and address and bank at 0.
- R10: From the rise of done, a refresh falls due every floor(64 ms / 4096 / period) cycles; 1562 cycles at 10 ns. The pending flag rises on the due clock. An all-bank precharge follows one cycle later, then an auto-refresh ceil(20 ns / period) cycles after that, and the pending flag clears with the refresh.
- R11: Grant is low from the clock on which a refresh becomes pending until ceil(70 ns / period) cycles after that refresh's auto-refresh. No host command is issued from the precharge through that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cas_lat | input | 3 | CAS latency written into the mode word |
| cfg_interleave | input | 1 | Burst type request, 1 = interleave |
| cfg_burst_code | input | 3 | Burst-length code (0,1,2,3,7) |
| host_req | input | 1 | Host wants the command bus |
| host_cmd | input | 3 | Host strobes {row, column, write-enable}, active low |
| host_addr | input | 12 | Host address |
| host_ba | input | 2 | Host bank address |
| host_gnt | output | 1 | Host owns the bus this cycle |
| init_done | output | 1 | Start-up sequence complete |
| ref_pending | output | 1 | A refresh is due and not yet issued |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address bus |
| sd_ba | output | 2 | Bank address |

## Verification
The properties assume that the refresh interval is much longer than one precharge-plus-refresh window, so that a new due pulse never lands while the previous one is still being serviced. They also assume that the configuration inputs stay stable around the cycle the mode word is taken. The mode-word check covers only writes made before done, because the host may legally send its own mode writes later. The stimulus keeps the defaults, where 1562 cycles dwarf the 9-cycle service window. It changes the configuration only while reset is held, and it drives random host commands, including mode-write codes, during start-up, where they must be discarded.

// File: rtl/wakeref_pkg.sv
package wakeref_pkg;

    // Command encoding on {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_MRS  = 3'b000,
        CMD_AREF = 3'b001,
        CMD_PRE  = 3'b010,
        CMD_NOP  = 3'b111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_BOOT_PRE,
        ST_BOOT_REF,
        ST_BOOT_MRS,
        ST_OPEN,
        ST_KEEP_REF
    } seq_state_e;

    typedef struct packed {
        logic [2:0] cas_lat;
        logic       interleave;
        logic [2:0] burst_code;
    } mode_cfg_t;

    localparam logic [2:0] BURST_FULL  = 3'b111;
    localparam int unsigned ALLBANK_BIT = 10;

    // Whole clocks covering a time in ns, rounded up
    function automatic int unsigned cyc_ceil(input longint unsigned t_ns,
                                             input longint unsigned period_ps);
        longint unsigned t_ps;
        t_ps = t_ns * 64'd1000;
        return int'((t_ps + period_ps - 64'd1) / period_ps);
    endfunction

    // Whole clocks per slot when a window is split into equal slots, rounded down
    function automatic int unsigned cyc_slot(input longint unsigned window_ns,
                                             input longint unsigned slots,
                                             input longint unsigned period_ps);
        longint unsigned t_ps;
        t_ps = window_ns * 64'd1000;
        return int'((t_ps / slots) / period_ps);
    endfunction

endpackage

// File: rtl/wakeref_gap.sv
module wakeref_gap #(
    parameter int unsigned W         = 16,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R4: once expired, the spacing timer stays expired until reloaded
    p_gap_settles_r4: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/wakeref_interval.sv
module wakeref_interval #(
    parameter int unsigned CYC = 1562,
    parameter int unsigned W   = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic due
);
    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == W'(CYC - 1));
    assign due    = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: the interval counter never runs past its period
    p_ivl_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= W'(CYC - 1));

    // R10: while idle the counter rests at zero
    p_ivl_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0) || run);

endmodule

// File: rtl/wakeref_modeword.sv
module wakeref_modeword
    import wakeref_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  mode_cfg_t         cfg,
    output logic [ADDR_W-1:0] word
);
    logic type_bit;

    // R6: full-page bursts are forced to sequential order
    assign type_bit = cfg.interleave && (cfg.burst_code != BURST_FULL);

    always_comb begin
        word      = '0;
        word[2:0] = cfg.burst_code;
        word[3]   = type_bit;
        word[6:4] = cfg.cas_lat;
    end

endmodule

// File: rtl/sdram_wake_refresh.sv
module sdram_wake_refresh
    import wakeref_pkg::*;
#(
    parameter int unsigned CLK_PS        = 10000,
    parameter int unsigned T_PAUSE_NS    = 200000,
    parameter int unsigned T_RP_NS       = 20,
    parameter int unsigned T_MRD_NS      = 20,
    parameter int unsigned T_RC_NS       = 70,
    parameter int unsigned REF_WINDOW_NS = 64000000,
    parameter int unsigned REF_ROWS      = 4096,
    parameter int unsigned INIT_REFS     = 8,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BA_W          = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_burst_code,
    input  logic              host_req,
    input  logic [2:0]        host_cmd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BA_W-1:0]   host_ba,
    output logic              host_gnt,
    output logic              init_done,
    output logic              ref_pending,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);
    localparam int unsigned PAUSE_CYC = cyc_ceil(T_PAUSE_NS, CLK_PS);
    localparam int unsigned RP_CYC    = cyc_ceil(T_RP_NS, CLK_PS);
    localparam int unsigned MRD_CYC   = cyc_ceil(T_MRD_NS, CLK_PS);
    localparam int unsigned RC_CYC    = cyc_ceil(T_RC_NS, CLK_PS);
    localparam int unsigned REF_CYC   = cyc_slot(REF_WINDOW_NS, REF_ROWS, CLK_PS);
    localparam int unsigned GAP_W     = $clog2(PAUSE_CYC + 1);
    localparam int unsigned IVL_W     = $clog2(REF_CYC + 1);
    localparam int unsigned REFS_W    = $clog2(INIT_REFS + 1);

    localparam logic [GAP_W-1:0] RP_LOAD  = GAP_W'((RP_CYC  > 0 ? RP_CYC  : 1) - 1);
    localparam logic [GAP_W-1:0] MRD_LOAD = GAP_W'((MRD_CYC > 0 ? MRD_CYC : 1) - 1);
    localparam logic [GAP_W-1:0] RC_LOAD  = GAP_W'((RC_CYC  > 0 ? RC_CYC  : 1) - 1);

    seq_state_e        state_q, state_d;
    logic [REFS_W-1:0] refs_q, refs_d;
    logic              done_q, gnt_q, pend_q, cke_q;
    logic              cs_n_q;
    sd_cmd_e           cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BA_W-1:0]   ba_q;

    logic              gap_zero, gap_load;
    logic [GAP_W-1:0]  gap_val;
    logic              due;
    logic              issue, pend_clr, done_set, gnt_d, host_pass;
    sd_cmd_e           issue_cmd;
    logic [ADDR_W-1:0] issue_addr;
    logic [ADDR_W-1:0] mode_word;
    logic [ADDR_W-1:0] pre_all_addr;
    mode_cfg_t         cfg;

    assign cfg = '{cas_lat: cfg_cas_lat, interleave: cfg_interleave, burst_code: cfg_burst_code};

    always_comb begin
        pre_all_addr               = '0;
        pre_all_addr[ALLBANK_BIT]  = 1'b1;
    end

    wakeref_gap #(.W(GAP_W), .RESET_VAL(PAUSE_CYC)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    wakeref_interval #(.CYC(REF_CYC), .W(IVL_W)) u_ivl (
        .clk (clk),
        .rst (rst),
        .run (done_q),
        .due (due)
    );

    wakeref_modeword #(.ADDR_W(ADDR_W)) u_mode (
        .cfg  (cfg),
        .word (mode_word)
    );

    // Sequencer: one command per expired spacing window
    always_comb begin
        state_d    = state_q;
        refs_d     = refs_q;
        issue      = 1'b0;
        issue_cmd  = CMD_NOP;
        issue_addr = '0;
        gap_load   = 1'b0;
        gap_val    = '0;
        pend_clr   = 1'b0;
        done_set   = 1'b0;
        case (state_q)
            ST_BOOT_PRE: if (gap_zero) begin
                issue      = 1'b1;
                issue_cmd  = CMD_PRE;
                issue_addr = pre_all_addr;
                gap_load   = 1'b1;
                gap_val    = RP_LOAD;
                refs_d     = '0;
                state_d    = ST_BOOT_REF;
            end
            ST_BOOT_REF: if (gap_zero) begin
                issue     = 1'b1;
                issue_cmd = CMD_AREF;
                gap_load  = 1'b1;
                gap_val   = RC_LOAD;
                refs_d    = refs_q + 1'b1;
                if (refs_q == REFS_W'(INIT_REFS - 1)) begin
                    state_d = ST_BOOT_MRS;
                end
            end
            ST_BOOT_MRS: if (gap_zero) begin
                issue      = 1'b1;
                issue_cmd  = CMD_MRS;
                issue_addr = mode_word;
                gap_load   = 1'b1;
                gap_val    = MRD_LOAD;
                state_d    = ST_OPEN;
            end
            ST_OPEN: if (gap_zero) begin
                if (!done_q) begin
                    done_set = 1'b1;
                end else if (pend_q && !gnt_q) begin
                    issue      = 1'b1;
                    issue_cmd  = CMD_PRE;
                    issue_addr = pre_all_addr;
                    gap_load   = 1'b1;
                    gap_val    = RP_LOAD;
                    state_d    = ST_KEEP_REF;
                end
            end
            ST_KEEP_REF: if (gap_zero) begin
                issue     = 1'b1;
                issue_cmd = CMD_AREF;
                gap_load  = 1'b1;
                gap_val   = RC_LOAD;
                pend_clr  = 1'b1;
                state_d   = ST_OPEN;
            end
            default: state_d = ST_BOOT_PRE;
        endcase
    end

    // Bus ownership: host only while open, idle, and no refresh due
    assign gnt_d     = host_req && done_q && (state_q == ST_OPEN) && gap_zero
                       && !pend_q && !due;
    assign host_pass = gnt_q && host_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT_PRE;
            refs_q  <= '0;
            done_q  <= 1'b0;
            gnt_q   <= 1'b0;
            pend_q  <= 1'b0;
            cke_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            cmd_q   <= CMD_NOP;
            addr_q  <= '0;
            ba_q    <= '0;
        end else begin
            state_q <= state_d;
            refs_q  <= refs_d;
            cke_q   <= 1'b1;
            done_q  <= done_q || done_set;
            gnt_q   <= gnt_d;
            if (due) begin
                pend_q <= 1'b1;
            end else if (pend_clr) begin
                pend_q <= 1'b0;
            end
            if (issue) begin
                cs_n_q <= 1'b0;
                cmd_q  <= issue_cmd;
                addr_q <= issue_addr;
                ba_q   <= '0;
            end else if (host_pass) begin
                cs_n_q <= 1'b0;
                cmd_q  <= sd_cmd_e'(host_cmd);
                addr_q <= host_addr;
                ba_q   <= host_ba;
            end else begin
                cs_n_q <= 1'b1;
                cmd_q  <= CMD_NOP;
                addr_q <= '0;
                ba_q   <= '0;
            end
        end
    end

    assign host_gnt    = gnt_q;
    assign init_done   = done_q;
    assign ref_pending = pend_q;
    assign sd_cke      = cke_q;
    assign sd_cs_n     = cs_n_q;
    assign sd_ras_n    = cmd_q[2];
    assign sd_cas_n    = cmd_q[1];
    assign sd_we_n     = cmd_q[0];
    assign sd_addr     = addr_q;
    assign sd_ba       = ba_q;

    // R1: clock enable never drops once raised
    p_cke_hold_r1: assert property (@(posedge clk) disable iff (rst)
        sd_cke |=> sd_cke);

    // R2: nothing is driven while the power-up pause runs
    p_boot_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT_PRE) |-> sd_cs_n);

    // R3: every precharge the sequencer issues closes all banks
    p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
        (!sd_cs_n && cmd_q == CMD_PRE && !$past(host_pass)) |-> sd_addr[ALLBANK_BIT]);

    // R6: start-up mode write never combines full page with interleave
    p_mrs_fullpage_r6: assert property (@(posedge clk) disable iff (rst)
        (!sd_cs_n && cmd_q == CMD_MRS && !done_q && sd_addr[2:0] == BURST_FULL)
        |-> !sd_addr[3]);

    // R7: grant only after start-up; done is sticky
    p_gnt_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        host_gnt |-> init_done);
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R9: the sequencer and the host never claim the same cycle
    p_no_clash_r9: assert property (@(posedge clk) disable iff (rst)
        !(issue && host_pass));

    // R11: a pending refresh takes the bus away from the host
    p_pend_drops_gnt_r11: assert property (@(posedge clk) disable iff (rst)
        ref_pending |=> !host_gnt);

endmodule

// File: tb/sdram_wake_refresh_tb_top.sv
module sdram_wake_refresh_tb_top;

    localparam int B_PERIOD_PS = 10000;
    localparam int B_PAUSE = (200000 * 1000 + B_PERIOD_PS - 1) / B_PERIOD_PS;
    localparam int B_RP    = (20 * 1000 + B_PERIOD_PS - 1) / B_PERIOD_PS;
    localparam int B_MRD   = (20 * 1000 + B_PERIOD_PS - 1) / B_PERIOD_PS;
    localparam int B_RC    = (70 * 1000 + B_PERIOD_PS - 1) / B_PERIOD_PS;
    localparam longint B_REF_L = (64'd64000000 * 64'd1000 / 64'd4096) / B_PERIOD_PS;
    localparam int B_REF   = int'(B_REF_L);
    localparam int B_NREF  = 8;

    localparam int T_PRE  = B_PAUSE + 1;
    localparam int T_REF0 = T_PRE + B_RP;
    localparam int T_MRS  = T_REF0 + B_NREF * B_RC;
    localparam int T_DONE = T_MRS + B_MRD;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cfg_cas_lat;
    logic        cfg_interleave;
    logic [2:0]  cfg_burst_code;
    logic        host_req;
    logic [2:0]  host_cmd;
    logic [11:0] host_addr;
    logic [1:0]  host_ba;
    logic        host_gnt, init_done, ref_pending;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [11:0] sd_addr;
    logic [1:0]  sd_ba;

    always #5 clk = ~clk;

    sdram_wake_refresh dut_i (
        .clk(clk), .rst(rst),
        .cfg_cas_lat(cfg_cas_lat), .cfg_interleave(cfg_interleave),
        .cfg_burst_code(cfg_burst_code),
        .host_req(host_req), .host_cmd(host_cmd), .host_addr(host_addr),
        .host_ba(host_ba),
        .host_gnt(host_gnt), .init_done(init_done), .ref_pending(ref_pending),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit reported = 1'b0;

    // Reference model state (behavioural, edge counted from reset release)
    int          e = 0;
    bit          x_cke, x_done, x_gnt, x_pend;
    logic [17:0] x_bus;   // {cs_n, ras, cas, we, addr, ba}
    string       x_tag;
    bit          prev_gnt;

    int          init_refs_seen = 0;
    logic [11:0] mrs_seen = '0;

    logic [31:0] lf = 32'h1ACE_B00C;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at edge %0d: actual %0h expected %0h", tag, e, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
    endtask

    // Model update on each rising edge, from inputs held since the last falling edge
    always @(posedge clk) begin
        started <= 1'b1;
        cycles  <= cycles + 1;
        if (rst) begin
            e = 0;
            x_cke = 0; x_done = 0; x_gnt = 0; x_pend = 0;
            x_bus = {1'b1, 3'b111, 12'h000, 2'b00};
            x_tag = "R1";
            prev_gnt = 0;
        end else begin
            int off, q, r;
            bit blocked;
            e = e + 1;
            x_cke = 1;
            x_bus = {1'b1, 3'b111, 12'h000, 2'b00};
            x_tag = (e <= T_PRE - 1) ? "R2" : "R9";
            x_done = (e >= T_DONE);
            off = e - T_DONE;
            q = (off >= 0) ? off / B_REF : 0;
            r = (off >= 0) ? off % B_REF : 0;
            blocked = (off >= 0) && (q >= 1) && (r <= B_RP + B_RC);
            x_pend  = (off >= 0) && (q >= 1) && (r <= B_RP);
            if (e == T_PRE) begin
                x_bus = {1'b0, 3'b010, 12'h400, 2'b00}; x_tag = "R3";
            end else if (e >= T_REF0 && e < T_MRS && ((e - T_REF0) % B_RC) == 0) begin
                x_bus = {1'b0, 3'b001, 12'h000, 2'b00}; x_tag = "R4";
            end else if (e == T_MRS) begin
                logic [11:0] w;
                w = '0;
                w[2:0] = cfg_burst_code;
                w[3]   = cfg_interleave && (cfg_burst_code != 3'b111);
                w[6:4] = cfg_cas_lat;
                x_bus = {1'b0, 3'b000, w, 2'b00};
                x_tag = (cfg_burst_code == 3'b111 && cfg_interleave) ? "R6" : "R5";
            end else if (off >= 0 && q >= 1 && r == 1) begin
                x_bus = {1'b0, 3'b010, 12'h400, 2'b00}; x_tag = "R10";
            end else if (off >= 0 && q >= 1 && r == 1 + B_RP) begin
                x_bus = {1'b0, 3'b001, 12'h000, 2'b00}; x_tag = "R10";
            end else if (prev_gnt && host_req) begin
                x_bus = {1'b0, host_cmd, host_addr, host_ba}; x_tag = "R8";
            end
            x_gnt = host_req && (e >= T_DONE + 1) && !blocked;
            prev_gnt = x_gnt;
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (started && !reported) begin
            logic [17:0] a_bus;
            a_bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba};
            check(sd_cke == x_cke, "R1", 32'(sd_cke), 32'(x_cke));
            check(a_bus == x_bus, x_tag, 32'(a_bus), 32'(x_bus));
            check(init_done == x_done, "R7", 32'(init_done), 32'(x_done));
            check(host_gnt == x_gnt, (x_pend || !x_gnt) ? "R11" : "R8",
                  32'(host_gnt), 32'(x_gnt));
            check(ref_pending == x_pend, "R10", 32'(ref_pending), 32'(x_pend));
            if (!rst && !init_done && !sd_cs_n && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b001)
                init_refs_seen++;
            if (!rst && !init_done && !sd_cs_n && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b000)
                mrs_seen = sd_addr;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 190000 && !reported) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual %0d cycles expected < 190000",
                     cycles);
            report();
            $finish;
        end
    end

    // mode: 0 = request low, 1 = request high, 2 = random
    task automatic drive(input int mode);
        @(negedge clk);
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        host_req  = (mode == 2) ? lf[5] : (mode == 1);
        host_cmd  = lf[2:0];
        host_addr = lf[14:3];
        host_ba   = lf[16:15];
    endtask

    initial begin
        rst = 1'b1;
        cfg_cas_lat = 3'd3; cfg_interleave = 1'b1; cfg_burst_code = 3'b111;
        host_req = 1'b0; host_cmd = 3'b000; host_addr = '0; host_ba = '0;
        repeat (5) drive(2);
        // R1: reset state seen at the ports
        check(sd_cke == 1'b0 && sd_cs_n == 1'b1 && !init_done && !host_gnt, "R1",
              {28'd0, sd_cke, sd_cs_n, init_done, host_gnt}, 32'b0100);
        rst = 1'b0;
        // Run 1: random host during start-up (R9), held through first refresh (R11),
        // idle through the second (R10), random after
        while (e < T_DONE + 3 * B_REF + 60) begin
            if (e < T_DONE)                    drive(2);
            else if (e < T_DONE + B_REF + 200)  drive(1);
            else if (e < T_DONE + 2*B_REF + 200) drive(0);
            else                                drive(2);
        end
        check(init_refs_seen == B_NREF, "R4", 32'(init_refs_seen), 32'(B_NREF));
        check(mrs_seen == 12'h037, "R6", 32'(mrs_seen), 32'h037);

        // Run 2: different mode word, host busy across the refresh
        rst = 1'b1;
        cfg_cas_lat = 3'd2; cfg_interleave = 1'b1; cfg_burst_code = 3'd2;
        init_refs_seen = 0;
        repeat (3) drive(0);
        rst = 1'b0;
        while (e < T_DONE + B_REF + 40) drive(1);
        check(init_refs_seen == B_NREF, "R4", 32'(init_refs_seen), 32'(B_NREF));
        check(mrs_seen == 12'h02A, "R5", 32'(mrs_seen), 32'h02A);
        report();
        $finish;
    end

endmodule